// File: doc/BRIEF.md
# ATM Cell Transmit Port with Double Buffer and PHY Polling

This block is the sending half of an ATM-layer cell bus master. A core-side writer loads one cell at a time, byte by byte, into one of two 64-byte cell slots. It then commits the slot. While the writer loads the second slot, the block empties the first one onto an 8-bit line bus toward one or more physical-layer devices. A cell is 53 bytes, and the remaining slot bytes are never sent. The first byte of each cell is marked with a start-of-cell strobe. A byte is transferred in every cycle in which the active-low enable is low.

Two static mode inputs select the operating style. In single-device mode the address bus stays at the null value 5'h1F. The writer may then choose per-cell handshake, where the device's ready flag gates only the start of a cell, or per-byte handshake, where the flag gates every byte. In multi-device mode the block scans device addresses 0 to NUM_PHY-1 while a cell waits. It picks the first device that answers ready and presents that address once more with the enable still high. It then sends the cell as one unbroken burst. In this mode only per-cell handshake is used. The next scan begins just after the device that was picked.

Top module: `cellbus_tx`

## Requirements
- R1: While and after reset, before any cell is committed: tx_enb_n = 1, tx_soc = 0, tx_addr = 5'h1F, wr_sel = 0, wr_ready = 1.
- R2: wr_commit in a cycle with wr_ready = 1 marks the slot numbered wr_sel as holding a cell, and wr_sel toggles. wr_ready is 0 while the slot numbered wr_sel still holds an unsent cell. A slot becomes free again once its 53rd byte has been transferred.
- R3: wr_en and wr_commit in a cycle with wr_ready = 0 have no effect: slot contents, wr_sel and the cells sent are unchanged.
- R4: Cells leave in commit order. Each cell leaves as bytes at indices 0 to 52 of its slot in ascending order, one byte per cycle with tx_enb_n = 0. tx_soc is 1 exactly on the byte at index 0.
- R5: Per-cell handshake in single-device mode (multi_phy = 0, octet_hs = 0): a cell starts only in the cycle after a clock edge at which tx_clav = 1 while a committed cell waits. Its 53 bytes are then transferred in 53 consecutive cycles, whatever tx_clav does.
- R6: Per-byte handshake in single-device mode (multi_phy = 0, octet_hs = 1): tx_enb_n is 0 in a cycle only if tx_clav was 1 at the clock edge that opened that cycle. When tx_clav is 0, the transfer pauses and later resumes with the next byte.
- R7: In single-device mode tx_addr is always 5'h1F.
- R8: In multi-device mode (multi_phy = 1), while a cell waits to be sent, tx_addr steps through 0 to NUM_PHY-1 one value per cycle, wrapping to 0. The tx_clav value at the edge ending a cycle is the answer for the address driven in that cycle. No value from NUM_PHY to 30 is ever driven.
- R9: In multi-device mode, when a polled address p answers tx_clav = 1, the next cycle drives p again with tx_enb_n = 1. The cell's first byte follows in the cycle after that. The next scan starts at p+1, wrapping to 0.
- R10: In multi-device mode octet_hs has no effect. Each cell is sent in 53 consecutive enabled cycles, and tx_addr is 5'h1F during the transfer and whenever no cell is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| multi_phy | input | 1 | 1 = multi-device polling mode, 0 = single device |
| octet_hs | input | 1 | 1 = per-byte handshake (single-device mode only) |
| wr_en | input | 1 | Write one byte into the slot selected by wr_sel |
| wr_idx | input | 6 | Byte index inside the slot |
| wr_data | input | 8 | Byte to write |
| wr_commit | input | 1 | Mark the current slot as holding a full cell |
| wr_sel | output | 1 | Slot the writer fills next |
| wr_ready | output | 1 | The slot numbered wr_sel is free |
| tx_data | output | 8 | Line data byte |
| tx_soc | output | 1 | Start-of-cell strobe, on byte 0 |
| tx_enb_n | output | 1 | Active-low transfer enable |
| tx_addr | output | 5 | Device address; 5'h1F is the null address |
| tx_clav | input | 1 | Ready flag from the addressed device |

## Verification
The hardest case to reach is a per-cell handshake transfer during which the device's ready flag drops. Both slots must also be full, so that the writer is locked out while the flag is low. The bench fills both slots with the flag held low. It fires writes and commits into the locked slot, then raises the flag. It drops the flag again ten bytes into the first cell, so that the unbroken burst, the blocked second start and the freed slot are all seen from the ports. In multi-device mode the device model answers from the live address bus. Two availability patterns, one of them only the highest address, force the scan to alternate between devices and to wrap.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;

   localparam int ADDR_W = 5;
   localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

   typedef enum logic [0:0] {
      SQ_IDLE,
      SQ_SEND
   } seq_state_e;

   typedef enum logic [1:0] {
      PL_IDLE,
      PL_SCAN,
      PL_PICK,
      PL_HOLD
   } poll_state_e;

endpackage

// File: rtl/cellbus_store.sv
module cellbus_store #(
   parameter int DATA_W    = 8,
   parameter int BUF_BYTES = 64,
   localparam int IDX_W    = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_commit,
   output logic              wr_sel,
   output logic              wr_ready,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_ready,
   input  logic              rd_release
);

   localparam int SLOTS = 2;

   logic              wr_ptr_q;
   logic              rd_ptr_q;
   logic              slot_full [SLOTS];
   logic [DATA_W-1:0] slot_q    [SLOTS];
   logic              wr_ok;
   logic              commit_ok;

   assign wr_ready  = !slot_full[wr_ptr_q];
   assign wr_ok     = wr_en && wr_ready;
   assign commit_ok = wr_commit && wr_ready;
   assign wr_sel    = wr_ptr_q;
   assign rd_ready  = slot_full[rd_ptr_q];
   assign rd_data   = slot_q[rd_ptr_q];

   for (genvar b = 0; b < SLOTS; b++) begin : g_slot
      logic [DATA_W-1:0] mem [BUF_BYTES];
      logic              full_q;
      logic              mine_wr;
      logic              mine_rd;

      assign mine_wr = (wr_ptr_q == 1'(b));
      assign mine_rd = (rd_ptr_q == 1'(b));

      always_ff @(posedge clk) begin
         if (wr_ok && mine_wr) begin
            mem[wr_idx] <= wr_data;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            full_q <= 1'b0;
         end else if (commit_ok && mine_wr) begin
            full_q <= 1'b1;
         end else if (rd_release && mine_rd) begin
            full_q <= 1'b0;
         end
      end

      assign slot_full[b] = full_q;
      assign slot_q[b]    = mem[rd_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= 1'b0;
         rd_ptr_q <= 1'b0;
      end else begin
         if (commit_ok) begin
            wr_ptr_q <= !wr_ptr_q;
         end
         if (rd_release) begin
            rd_ptr_q <= !rd_ptr_q;
         end
      end
   end

   // R2: an accepted commit hands the writer the other slot
   a_r2_commit_swaps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit && wr_ready) |=> (wr_sel != $past(wr_sel)));

   // R2: a slot is released only while it holds a cell
   a_r2_release_full: assert property (@(posedge clk) disable iff (!rst_n)
      rd_release |-> rd_ready);

   // R3: a commit into an occupied slot is dropped
   a_r3_blocked_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit && !wr_ready) |=> $stable(wr_sel));

endmodule

// File: rtl/cellbus_poll.sv
module cellbus_poll
   import cellbus_pkg::*;
#(
   parameter int NUM_PHY = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              poll_req,
   input  logic              seq_busy,
   input  logic              tx_clav,
   output logic [ADDR_W-1:0] tx_addr,
   output logic              pick
);

   poll_state_e       st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] start_q;
   logic [ADDR_W-1:0] addr_inc;

   if (NUM_PHY == 1) begin : g_one
      assign addr_inc = '0;
   end else begin : g_wrap
      assign addr_inc = (addr_q == ADDR_W'(NUM_PHY - 1)) ? '0 : addr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= PL_IDLE;
         addr_q  <= NULL_ADDR;
         start_q <= '0;
      end else begin
         case (st_q)
            PL_IDLE: begin
               addr_q <= NULL_ADDR;
               if (enable && poll_req) begin
                  st_q   <= PL_SCAN;
                  addr_q <= start_q;
               end
            end
            PL_SCAN: begin
               if (tx_clav) begin
                  st_q    <= PL_PICK;
                  start_q <= addr_inc;
               end else begin
                  addr_q <= addr_inc;
               end
            end
            PL_PICK: begin
               st_q   <= PL_HOLD;
               addr_q <= NULL_ADDR;
            end
            PL_HOLD: begin
               if (!seq_busy) begin
                  st_q <= PL_IDLE;
               end
            end
            default: begin
               st_q   <= PL_IDLE;
               addr_q <= NULL_ADDR;
            end
         endcase
      end
   end

   assign tx_addr = addr_q;
   assign pick    = (st_q == PL_PICK);

   // R9: a ready answer keeps the address for one selection cycle
   a_r9_pick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PL_SCAN && tx_clav) |=> (pick && $stable(tx_addr)));

endmodule

// File: rtl/cellbus_seq.sv
module cellbus_seq
   import cellbus_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int IDX_W      = 6,
   localparam int CNT_W     = $clog2(CELL_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              multi,
   input  logic              octet_req,
   input  logic              cell_ready,
   input  logic              tx_clav,
   input  logic              pick,
   input  logic [DATA_W-1:0] rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              rd_release,
   output logic              busy,
   output logic              poll_req,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_soc,
   output logic              tx_enb_n
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_BYTES);

   seq_state_e        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] data_q;
   logic              soc_q;
   logic              enb_n_q;
   logic              octet_eff;
   logic              start;
   logic              step;

   assign octet_eff  = octet_req && !multi;
   assign start      = (st_q == SQ_IDLE) && cell_ready && (multi ? pick : tx_clav);
   assign step       = !octet_eff || tx_clav;
   assign rd_idx     = IDX_W'(cnt_q);
   assign rd_release = (st_q == SQ_SEND) && (cnt_q == LAST);
   assign busy       = (st_q == SQ_SEND);
   assign poll_req   = (st_q == SQ_IDLE) && cell_ready && multi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         cnt_q   <= '0;
         data_q  <= '0;
         soc_q   <= 1'b0;
         enb_n_q <= 1'b1;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               soc_q   <= 1'b0;
               enb_n_q <= 1'b1;
               cnt_q   <= '0;
               if (start) begin
                  st_q    <= SQ_SEND;
                  data_q  <= rd_data;
                  soc_q   <= 1'b1;
                  enb_n_q <= 1'b0;
                  cnt_q   <= CNT_W'(1);
               end
            end
            SQ_SEND: begin
               soc_q <= 1'b0;
               if (cnt_q == LAST) begin
                  st_q    <= SQ_IDLE;
                  enb_n_q <= 1'b1;
                  cnt_q   <= '0;
               end else if (step) begin
                  data_q  <= rd_data;
                  enb_n_q <= 1'b0;
                  cnt_q   <= cnt_q + 1'b1;
               end else begin
                  enb_n_q <= 1'b1;
               end
            end
            default: begin
               st_q    <= SQ_IDLE;
               enb_n_q <= 1'b1;
            end
         endcase
      end
   end

   assign tx_data  = data_q;
   assign tx_soc   = soc_q;
   assign tx_enb_n = enb_n_q;

   // R4: the start strobe only marks a transferred byte
   a_r4_soc_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      tx_soc |-> !tx_enb_n);

   // R5 / R10: in per-cell handshake an unfinished burst never pauses
   a_r5_burst_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
      (!octet_eff && busy && !rd_release) |=> !tx_enb_n);

   // R6: per-byte handshake transfers only after a ready flag
   a_r6_byte_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (octet_eff && !tx_enb_n) |-> $past(tx_clav));

endmodule

// File: rtl/cellbus_tx.sv
module cellbus_tx
   import cellbus_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int BUF_BYTES  = 64,
   parameter int CELL_BYTES = 53,
   parameter int NUM_PHY    = 6,
   localparam int IDX_W     = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              multi_phy,
   input  logic              octet_hs,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_commit,
   output logic              wr_sel,
   output logic              wr_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_soc,
   output logic              tx_enb_n,
   output logic [4:0]        tx_addr,
   input  logic              tx_clav
);

   if (CELL_BYTES < 1 || CELL_BYTES > BUF_BYTES) begin : g_bad_cell
      $error("cellbus_tx: CELL_BYTES must lie in 1..BUF_BYTES");
   end
   if ((1 << IDX_W) != BUF_BYTES) begin : g_bad_buf
      $error("cellbus_tx: BUF_BYTES must be a power of two");
   end
   if (NUM_PHY < 1 || NUM_PHY > 31) begin : g_bad_phy
      $error("cellbus_tx: NUM_PHY must lie in 1..31");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("cellbus_tx: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_data;
   logic              rd_ready;
   logic              rd_release;
   logic              seq_busy;
   logic              poll_req;
   logic              pick;
   logic [ADDR_W-1:0] poll_addr;

   cellbus_store #(
      .DATA_W    (DATA_W),
      .BUF_BYTES (BUF_BYTES)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .wr_commit  (wr_commit),
      .wr_sel     (wr_sel),
      .wr_ready   (wr_ready),
      .rd_idx     (rd_idx),
      .rd_data    (rd_data),
      .rd_ready   (rd_ready),
      .rd_release (rd_release)
   );

   cellbus_poll #(
      .NUM_PHY (NUM_PHY)
   ) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (multi_phy),
      .poll_req (poll_req),
      .seq_busy (seq_busy),
      .tx_clav  (tx_clav),
      .tx_addr  (poll_addr),
      .pick     (pick)
   );

   cellbus_seq #(
      .DATA_W     (DATA_W),
      .CELL_BYTES (CELL_BYTES),
      .IDX_W      (IDX_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .multi      (multi_phy),
      .octet_req  (octet_hs),
      .cell_ready (rd_ready),
      .tx_clav    (tx_clav),
      .pick       (pick),
      .rd_data    (rd_data),
      .rd_idx     (rd_idx),
      .rd_release (rd_release),
      .busy       (seq_busy),
      .poll_req   (poll_req),
      .tx_data    (tx_data),
      .tx_soc     (tx_soc),
      .tx_enb_n   (tx_enb_n)
   );

   assign tx_addr = poll_addr;

   // R7: single-device mode never leaves the null address
   a_r7_single_null: assert property (@(posedge clk) disable iff (!rst_n)
      !multi_phy |-> (tx_addr == NULL_ADDR));

   // R8: only real device numbers or the null value appear
   a_r8_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_addr == NULL_ADDR) || (tx_addr < 5'(NUM_PHY)));

   // R9: the enable falls right after a device address was held
   a_r9_select_before_send: assert property (@(posedge clk) disable iff (!rst_n)
      (multi_phy && $fell(tx_enb_n)) |-> ($past(tx_addr) != NULL_ADDR));

   // R10: the address bus rests at null during a multi-device transfer
   a_r10_null_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (multi_phy && !tx_enb_n) |-> (tx_addr == NULL_ADDR));

endmodule

// File: tb/cellbus_tx_tb.sv
module cellbus_tx_tb;

   localparam int NPHY  = 6;
   localparam int CELLN = 53;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       multi_phy = 1'b0;
   logic       octet_hs = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_idx = '0;
   logic [7:0] wr_data = '0;
   logic       wr_commit = 1'b0;
   logic       wr_sel;
   logic       wr_ready;
   logic [7:0] tx_data;
   logic       tx_soc;
   logic       tx_enb_n;
   logic [4:0] tx_addr;
   logic       tx_clav;

   logic        sphy_clav = 1'b0;
   logic [31:0] avail = '0;
   logic        jitter_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   assign tx_clav = multi_phy ? ((tx_addr != 5'h1F) && avail[tx_addr]) : sphy_clav;

   cellbus_tx #(.NUM_PHY(NPHY)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .multi_phy (multi_phy),
      .octet_hs  (octet_hs),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .wr_commit (wr_commit),
      .wr_sel    (wr_sel),
      .wr_ready  (wr_ready),
      .tx_data   (tx_data),
      .tx_soc    (tx_soc),
      .tx_enb_n  (tx_enb_n),
      .tx_addr   (tx_addr),
      .tx_clav   (tx_clav)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q [$];
   bit   mid = 0;
   int   bcnt = 0;
   int   exp_start = 0;
   logic [4:0] prev_addr = 5'h1F;
   logic prev_enb = 1'b1;
   logic prev_clav = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] cell_byte(input int seed, input int i);
      return 8'((seed * 37) ^ (i * 13) ^ (i >> 2));
   endfunction

   // clav jitter for per-byte handshake, changed away from the edge
   always @(posedge clk) begin
      #2;
      if (jitter_en) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         sphy_clav = lfsr[0] | lfsr[3];
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (!tx_enb_n) begin
            logic [7:0] eb;
            if (!mid) begin
               chk(tx_soc == 1'b1, "R4 soc on first byte", int'(tx_soc), 1);
               if (multi_phy) begin
                  int p;
                  p = -1;
                  for (int k = 0; k < NPHY; k++) begin
                     int c;
                     c = (exp_start + k) % NPHY;
                     if (p < 0 && avail[c]) p = c;
                  end
                  chk(int'(prev_addr) == p, "R9 selected device", int'(prev_addr), p);
                  chk(prev_enb == 1'b1, "R9 select cycle enable high", int'(prev_enb), 1);
                  exp_start = (p + 1) % NPHY;
               end else begin
                  chk(prev_clav == 1'b1, "R5 start needs clav", int'(prev_clav), 1);
               end
               mid = 1;
               bcnt = 0;
            end else begin
               chk(tx_soc == 1'b0, "R4 soc only on byte 0", int'(tx_soc), 0);
            end
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected byte", int'(tx_data), -1);
            end else begin
               eb = exp_q.pop_front();
               chk(tx_data == eb, "R4 byte value", int'(tx_data), int'(eb));
            end
            if (octet_hs && !multi_phy)
               chk(prev_clav == 1'b1, "R6 byte after clav", int'(prev_clav), 1);
            if (multi_phy)
               chk(tx_addr == 5'h1F, "R10 null address in burst", int'(tx_addr), 31);
            bcnt++;
            if (bcnt == CELLN) mid = 0;
         end else if (mid && !(octet_hs && !multi_phy)) begin
            chk(1'b0, multi_phy ? "R10 burst gap" : "R5 burst gap", bcnt, CELLN);
            mid = 0;
         end
         if (!multi_phy) begin
            if (tx_addr != 5'h1F) chk(1'b0, "R7 single-mode address", int'(tx_addr), 31);
         end else begin
            if (tx_addr != 5'h1F && tx_addr >= 5'(NPHY))
               chk(1'b0, "R8 address range", int'(tx_addr), NPHY - 1);
            if (prev_enb && tx_enb_n && prev_addr != 5'h1F && tx_addr != 5'h1F) begin
               int want;
               want = avail[prev_addr] ? int'(prev_addr) : (int'(prev_addr) + 1) % NPHY;
               chk(int'(tx_addr) == want, "R8 scan order", int'(tx_addr), want);
            end
            if (exp_q.size() == 0 && !mid && tx_enb_n)
               if (tx_addr != 5'h1F) chk(1'b0, "R10 idle null", int'(tx_addr), 31);
         end
         prev_addr = tx_addr;
         prev_enb  = tx_enb_n;
         prev_clav = tx_clav;
      end
   end

   task automatic write_cell(input int seed);
      do @(negedge clk); while (!wr_ready);
      for (int i = 0; i < CELLN; i++) begin
         wr_en   = 1'b1;
         wr_idx  = 6'(i);
         wr_data = cell_byte(seed, i);
         exp_q.push_back(cell_byte(seed, i));
         @(negedge clk);
      end
      wr_en = 1'b0;
      // stale bytes past the cell end must never be sent
      wr_en = 1'b1; wr_idx = 6'd60; wr_data = 8'h5A;
      @(negedge clk);
      wr_en = 1'b0;
      wr_commit = 1'b1;
      @(negedge clk);
      wr_commit = 1'b0;
   endtask

   task automatic drain;
      while (exp_q.size() != 0 || mid) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   initial begin
      bit sel_before;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tx_enb_n == 1'b1, "R1 enable idle", int'(tx_enb_n), 1);
      chk(tx_soc == 1'b0, "R1 soc idle", int'(tx_soc), 0);
      chk(tx_addr == 5'h1F, "R1 null address", int'(tx_addr), 31);
      chk(wr_sel == 1'b0, "R1 wr_sel", int'(wr_sel), 0);
      chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_enb_n == 1'b1 && wr_ready == 1'b1, "R1 after reset", int'(tx_enb_n), 1);

      // per-cell handshake, single device, device not ready
      sphy_clav = 1'b0;
      write_cell(1);
      chk(wr_sel == 1'b1, "R2 select toggles", int'(wr_sel), 1);
      write_cell(2);
      chk(wr_sel == 1'b0, "R2 select toggles back", int'(wr_sel), 0);
      chk(wr_ready == 1'b0, "R2 both slots full", int'(wr_ready), 0);
      // R3: locked writes and commits are ignored
      sel_before = wr_sel;
      wr_en = 1'b1; wr_idx = 6'd0; wr_data = 8'hEE; wr_commit = 1'b1;
      repeat (3) @(negedge clk);
      wr_en = 1'b0; wr_commit = 1'b0;
      @(negedge clk);
      chk(wr_sel == sel_before, "R3 select unchanged", int'(wr_sel), int'(sel_before));
      chk(wr_ready == 1'b0, "R3 still full", int'(wr_ready), 0);
      chk(tx_enb_n == 1'b1, "R5 no start without clav", int'(tx_enb_n), 1);
      // start, then drop clav mid-burst
      sphy_clav = 1'b1;
      while (!(mid && bcnt >= 10)) @(negedge clk);
      sphy_clav = 1'b0;
      while (exp_q.size() > CELLN || mid) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(wr_ready == 1'b1, "R2 slot freed after last byte", int'(wr_ready), 1);
      chk(tx_enb_n == 1'b1, "R5 second cell waits for clav", int'(tx_enb_n), 1);
      sphy_clav = 1'b1;
      drain();

      // per-byte handshake, single device
      octet_hs = 1'b1;
      jitter_en = 1'b1;
      write_cell(3);
      write_cell(4);
      write_cell(5);
      drain();
      jitter_en = 1'b0;
      sphy_clav = 1'b0;
      repeat (3) @(negedge clk);

      // multi-device, octet_hs left set (must be ignored)
      multi_phy = 1'b1;
      avail = 32'b010010;
      exp_start = 0;
      repeat (3) @(negedge clk);
      chk(tx_addr == 5'h1F, "R10 idle null address", int'(tx_addr), 31);
      write_cell(6);
      write_cell(7);
      write_cell(8);
      write_cell(9);
      drain();
      avail = 32'b100000;
      write_cell(10);
      write_cell(11);
      drain();
      chk(exp_q.size() == 0, "R4 all cells delivered", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule